// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Controller

This block collects level-sensitive interrupt lines and steers each one to any subset of the CPUs of a small multiprocessor, either on the normal interrupt line or on the fast interrupt line. Software programs it through a plain 32-bit read/write register bus. A shared region holds the global control word, the enable set/clear ports for shared sources and one routing word per source. Each CPU also has its own register window with a pending view, a priority word, an acknowledge port, a local mask and mask/unmask ports for the low-numbered private sources.

Shared sources are switched on and off by writing their number to a set port or a clear port, so that two agents never race on a read-modify-write of a bitmask. Sources below 32 are private: each CPU masks them on its own through its window. The acknowledge port gives a CPU the lowest-numbered source that is pending for it, which is the only arbitration the block performs.

The bus is a single-cycle strobe interface: a write takes effect on the clock edge at which it is sampled, and read data appears on the edge after the read strobe. The shared region occupies addresses with bit 15 clear; CPU c's window starts at 0x8000 + 0x100*c.

Top module: `irq_router`

## Requirements
- R1: After reset every enable, route, priority and local mask is zero, the global enable is off, `irq_o` and `fiq_o` are low and every CPU's acknowledge reads 0x3FF.
- R2: The control word at 0x000 holds the global enable in bit 0 (read/write) and returns the number of implemented sources in bits [11:2]; with the global enable off no source is pending for any CPU.
- R3: Writing n to 0x030 enables shared source n and writing n to 0x034 disables it, for 32 <= n < NUM_SRC; a write naming a number below 32 or at or above NUM_SRC changes nothing.
- R4: Writing n < 32 to window offset 0x4C unmasks private source n for that CPU only, and to 0x48 masks it; numbers of 32 or more written there change nothing.
- R5: The routing word of source n sits at 0x100 + 4*n; bit c routes the source to CPU c as a normal interrupt and bit 8+c routes it as a fast interrupt; the word reads back as written.
- R6: Source n is pending for CPU c when its input is high, it is enabled (shared enable, or CPU c's private unmask), it is routed to c in either bit and the global enable is set; window offset 0x10 + 4*k shows sources 32k..32k+31 in bits 0..31 for that CPU.
- R7: Window offset 0x44 returns the lowest-numbered source pending for that CPU, or 0x3FF when none is.
- R8: `irq_o[c]` is the OR of CPU c's pending sources routed as normal interrupts and `fiq_o[c]` the OR of those routed as fast interrupts, both registered one clock after the state and inputs they depend on.
- R9: Window offset 0x40 is a 4-bit priority word per CPU, read/write, reset to 0, independent between CPUs.
- R10: Window offset 0x54 is a local mask per CPU; private source PERF_SRC (default 5) is pending for CPU c only while bit c of CPU c's local mask is set.
- R11: Read data is registered and appears one clock after the read strobe; a read sees every write sampled on an earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | NUM_SRC | Level-sensitive source lines |
| irq_o | output | NUM_CPU | Normal interrupt per CPU |
| fiq_o | output | NUM_CPU | Fast interrupt per CPU |

## Verification
An enable write and a change on the same source's input line can land in the same clock, and so can a reprogramming of one CPU's view while another CPU observes the same source. The bench raises a source line in the very cycle that writes its number to the set port and expects both outputs still low after that edge, then the normal line of one CPU and the fast line of the other high one edge later. The private mask ports are exercised on one CPU while the other CPU's acknowledge is read, which must not move.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NUM_SRC  = 128,
  parameter int NUM_CPU  = 2,
  parameter int PCPU_SRC = 32,
  parameter int PERF_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [15:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [NUM_CPU-1:0] irq_o,
  output logic [NUM_CPU-1:0] fiq_o
);
  localparam int IW = $clog2(NUM_SRC);
  localparam int CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam int NWORDS = NUM_SRC / 32;
  localparam logic [9:0] NSRC_N = 10'(NUM_SRC);
  localparam logic [9:0] PCPU_N = 10'(PCPU_SRC);
  localparam logic [9:0] NONE = 10'h3FF;
  localparam logic [15:0] ROUTE_END = 16'(256 + 4 * NUM_SRC);

  logic                              gen_en;
  logic [NUM_SRC-1:0]                g_en;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]   p_en;
  logic [NUM_SRC-1:0][NUM_CPU-1:0]   irq_rt, fiq_rt;
  logic [NUM_CPU-1:0][3:0]           prio;
  logic [NUM_CPU-1:0][NUM_CPU-1:0]   lmask;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]   pend, pend_i, pend_f;
  logic [NUM_CPU-1:0][9:0]           ack;
  logic [NUM_CPU-1:0]                irq_q, fiq_q;
  logic [31:0]                       rd_val;

  wire [9:0]    num    = bus_wdata[9:0];
  wire [IW-1:0] sidx   = bus_wdata[IW-1:0];
  wire          glob_ok = (num >= PCPU_N) && (num < NSRC_N);
  wire          pc_ok  = num < PCPU_N;
  wire          in_win = bus_addr[15];
  wire          win_ok = in_win && (bus_addr[11:8] < 4'(NUM_CPU));
  wire [CW-1:0] csel   = bus_addr[8 +: CW];
  wire [7:0]    off    = bus_addr[7:0];
  wire [15:0]   roff   = bus_addr - 16'h0100;
  wire [IW-1:0] ridx   = roff[IW+1:2];
  wire          route_a = !in_win && bus_addr >= 16'h0100 && bus_addr < ROUTE_END && bus_addr[1:0] == 2'b00;
  wire          ctrl_a = bus_addr == 16'h0000;
  wire          set_hit = bus_wr && bus_addr == 16'h0030;
  wire          clr_hit = bus_wr && bus_addr == 16'h0034;
  wire [1:0]    cw     = bus_addr[3:2];

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:16], bus_addr[14:12]};

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int n = 0; n < NUM_SRC; n++) begin
        logic en;
        if (n < PCPU_SRC) en = p_en[c][n] && (n != PERF_SRC || lmask[c][c]);
        else              en = g_en[n];
        pend[c][n]   = gen_en && src_in[n] && en && (irq_rt[n][c] || fiq_rt[n][c]);
        pend_i[c][n] = pend[c][n] && irq_rt[n][c];
        pend_f[c][n] = pend[c][n] && fiq_rt[n][c];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      ack[c] = NONE;
      for (int n = NUM_SRC - 1; n >= 0; n--)
        if (pend[c][n]) ack[c] = 10'(n);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      g_en   <= '0;
      p_en   <= '0;
      irq_rt <= '0;
      fiq_rt <= '0;
      prio   <= '0;
      lmask  <= '0;
      irq_q  <= '0;
      fiq_q  <= '0;
    end else begin
      if (bus_wr && ctrl_a) gen_en <= bus_wdata[0];
      if (set_hit && glob_ok) g_en[sidx] <= 1'b1;
      if (clr_hit && glob_ok) g_en[sidx] <= 1'b0;
      if (bus_wr && route_a) begin
        irq_rt[ridx] <= bus_wdata[NUM_CPU-1:0];
        fiq_rt[ridx] <= bus_wdata[8 +: NUM_CPU];
      end
      if (bus_wr && win_ok) begin
        case (off)
          8'h40: prio[csel] <= bus_wdata[3:0];
          8'h48: if (pc_ok) p_en[csel][sidx] <= 1'b0;
          8'h4C: if (pc_ok) p_en[csel][sidx] <= 1'b1;
          8'h54: lmask[csel] <= bus_wdata[NUM_CPU-1:0];
          default: ;
        endcase
      end
      for (int c = 0; c < NUM_CPU; c++) begin
        irq_q[c] <= |pend_i[c];
        fiq_q[c] <= |pend_f[c];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (!in_win) begin
      if (ctrl_a) rd_val = {20'b0, NSRC_N, 1'b0, gen_en};
      else if (route_a) begin
        rd_val[NUM_CPU-1:0]   = irq_rt[ridx];
        rd_val[8 +: NUM_CPU]  = fiq_rt[ridx];
      end
    end else if (win_ok) begin
      case (off)
        8'h10, 8'h14, 8'h18, 8'h1C:
          if (32'(cw) < NWORDS) rd_val = pend[csel][IW'({cw, 5'b0}) +: 32];
        8'h40: rd_val[3:0] = prio[csel];
        8'h44: rd_val[9:0] = ack[csel];
        8'h54: rd_val[NUM_CPU-1:0] = lmask[csel];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0 && fiq_o == '0 && g_en == '0));

  p_gen_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (irq_o == '0 && fiq_o == '0));

  p_set_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && glob_ok) |=> g_en[$past(sidx)]);

  p_clr_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && glob_ok) |=> !g_en[$past(sidx)]);

  p_bad_num_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_hit || clr_hit) && !glob_ok) |=> $stable(g_en));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    p_ack_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[c] == '0) |-> (ack[c] == NONE));
    p_ack_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[c] != NONE) |-> pend[c][ack[c][IW-1:0]]);
  end
endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb_top;
  localparam int NUM_SRC = 128;
  localparam int NUM_CPU = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               bus_wr = 1'b0;
  logic               bus_rd = 1'b0;
  logic [15:0]        bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic [NUM_SRC-1:0] src_in = '0;
  logic [NUM_CPU-1:0] irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  irq_router #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_o(irq_o), .fiq_o(fiq_o));

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 and R2: reset state and source count
    chk("R1 outputs", {30'b0, fiq_o, irq_o}, 32'h0);
    rd(16'h0000, 32'h0000_0200, "R2 ctrl reset");
    rd(16'h8044, 32'h3FF, "R1 ack cpu0");
    rd(16'h8144, 32'h3FF, "R1 ack cpu1");
    rd(16'h8040, 32'h0, "R9 prio reset");
    wr(16'h0000, 32'h1);
    rd(16'h0000, 32'h0000_0201, "R2 ctrl enable");
    // R5 routing: src 40 -> cpu0 IRQ, cpu1 FIQ
    wr(16'h01A0, 32'h0000_0201);
    rd(16'h01A0, 32'h0000_0201, "R5 route readback");
    // R6: input high but not enabled
    wr(16'h01C8, 32'h1);
    src_in[50] = 1'b1;
    settle();
    rd(16'h8044, 32'h3FF, "R6 disabled source");
    chk("R6 irq idle", {31'b0, irq_o[0]}, 32'h0);
    // R8 same-cycle: enable write and input rise together
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 16'h0030; bus_wdata = 32'd40; src_in[40] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R8 irq0 before", {31'b0, irq_o[0]}, 32'h0);
    chk("R8 fiq1 before", {31'b0, fiq_o[1]}, 32'h0);
    @(negedge clk);
    chk("R8 irq0 after", {31'b0, irq_o[0]}, 32'h1);
    chk("R8 fiq1 after", {31'b0, fiq_o[1]}, 32'h1);
    chk("R8 fiq0 stays low", {31'b0, fiq_o[0]}, 32'h0);
    rd(16'h8044, 32'd40, "R7 ack cpu0");
    rd(16'h8144, 32'd40, "R7 ack cpu1");
    rd(16'h8014, 32'h0000_0100, "R6 cause word1");
    // R7 lowest pick with two pending
    wr(16'h0030, 32'd50);
    rd(16'h8044, 32'd40, "R7 lowest of 40 and 50");
    rd(16'h8014, 32'h0004_0100, "R6 cause two bits");
    // R3: set-enable with a private number is ignored
    wr(16'h0128, 32'h1);
    src_in[10] = 1'b1;
    wr(16'h0030, 32'd10);
    rd(16'h8044, 32'd40, "R3 low number ignored");
    wr(16'h0030, 32'd200);
    rd(16'h8044, 32'd40, "R3 out of range ignored");
    // R4: per-CPU unmask
    wr(16'h814C, 32'd10);
    rd(16'h8044, 32'd40, "R4 other cpu unmask");
    wr(16'h804C, 32'd10);
    rd(16'h8044, 32'd10, "R4 unmask own cpu");
    rd(16'h8010, 32'h0000_0400, "R6 cause word0");
    wr(16'h8048, 32'd10);
    rd(16'h8044, 32'd40, "R4 mask own cpu");
    wr(16'h8048, 32'd40);
    rd(16'h8044, 32'd40, "R4 high number ignored");
    // R3 clear-enable
    wr(16'h0034, 32'd40);
    rd(16'h8044, 32'd50, "R3 clear enable");
    settle();
    chk("R3 fiq1 drops", {31'b0, fiq_o[1]}, 32'h0);
    chk("R3 irq0 from 50", {31'b0, irq_o[0]}, 32'h1);
    // R2: global disable
    wr(16'h0000, 32'h0);
    rd(16'h8044, 32'h3FF, "R2 global off ack");
    settle();
    chk("R2 global off irq", {31'b0, irq_o[0]}, 32'h0);
    wr(16'h0000, 32'h1);
    // R9 priority words
    wr(16'h8040, 32'h7);
    rd(16'h8040, 32'h7, "R9 prio cpu0");
    rd(16'h8140, 32'h0, "R9 prio cpu1");
    // R10 local mask gate on source 5
    wr(16'h0114, 32'h1);
    wr(16'h804C, 32'd5);
    src_in[5] = 1'b1;
    rd(16'h8044, 32'd50, "R10 gated by local mask");
    wr(16'h8054, 32'h1);
    rd(16'h8054, 32'h1, "R10 local mask readback");
    rd(16'h8044, 32'd5, "R10 unmasked perf source");
    src_in[5] = 1'b0;
    rd(16'h8044, 32'd50, "R6 level follows input");
    // R11: read right after write sees new value
    wr(16'h01A0, 32'h0000_0003);
    rd(16'h01A0, 32'h0000_0003, "R11 read after write");
    settle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule